// File: doc/BRIEF.md
# Hash Engine Register Front End

This block is the register-bus face of a hash engine that computes MD5, SHA-1, SHA-224 and SHA-256 digests. Software programs it over a simple 32-bit read/write bus. It sets a 64-bit message length in bits and picks the algorithm and the input byte order. It then drains the finished digest one 32-bit word per read from a single popping address. The compression logic sits outside. It gets a hold level, a one-cycle start strobe, the algorithm, the byte order and the length. It hands back digest words through a push port and reports the end of a digest with a done strobe.

Four sticky status flags report that words have arrived, that a whole result set has finished, that software read the queue while it was empty, and that message data reached the engine before any configuration. A fifth, raw level shows that the queue is not empty. An enable mask selects which of these five drive the single interrupt line. A soft-reset register holds the engine and wipes the per-message state. A usual message runs as follows: hold then release, write the length, write the control word, stream the data, take the interrupt, then pop the digest.

Top module: `hash_reg_shell`

## Requirements
- R1: After the synchronous reset, irq is 0 and the reset, status, control and both length registers read 0. Offset 0x50 reads the REVISION parameter and offsets 0x60 and 0x70 read ID_WORD0 and ID_WORD1. Writes to these three constant offsets have no effect.
- R2: Writing 1 to bit 0 at offset 0x00 sets core_hold from the next cycle on. On that same clock edge it empties the result queue and clears the sticky status bits, both length words, the control word and the configured state. While the hold is set, writes to the length and control offsets are ignored. The enable mask keeps its value. Writing 0 releases the hold.
- R3: Offset 0x04 holds the upper and offset 0x08 the lower 32 bits of the message bit length. Both read back, and core_len_bits presents them concatenated as {upper, lower}.
- R4: Control is at offset 0x0C. Bits [1:0] select the algorithm (0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256) and bits [9:8] select the byte order. Both appear on core_algo and core_order. A control write made outside hold raises core_start for exactly the following cycle.
- R5: The result queue keeps the pushed words in arrival order. It takes at most 4, 5, 7 or 8 words after each control write, for MD5, SHA-1, SHA-224 and SHA-256 respectively, and never more than DEPTH words in total. Pushes beyond either limit are dropped. Offset 0x40 reads the current word count.
- R6: A read of offset 0x1C returns the oldest queued word on bus_rdata in the cycle after the read and removes that word. If a push and a pop happen in the same cycle, both take effect.
- R7: A read of offset 0x1C when the queue is empty returns 0, sets status bit 2 and leaves the word count unchanged.
- R8: Status at offset 0x10 has these bits. Bit 0 is set by an accepted push. Bit 1 is set by core_done. Bit 3 is set by msg_beat when no control write has happened since the last reset or hold. Bit 8 reads 1 while the queue holds at least one word.
- R9: Writing a mask to offset 0x18 clears each of status bits [3:0] whose mask bit is 1. A set event in the same cycle wins over the clear. Bit 8 is not affected, and offset 0x18 reads 0.
- R10: Offset 0x14 holds enable bits [3:0] and [8]. irq is high whenever some status bit is 1 and its enable bit is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| msg_beat | input | 1 | A message data word is being written to the engine |
| core_hold | output | 1 | Engine held in soft reset |
| core_start | output | 1 | One-cycle start after a control write |
| core_algo | output | 2 | Selected algorithm |
| core_order | output | 2 | Selected input byte order |
| core_len_bits | output | 64 | Message length in bits |
| core_push | input | 1 | Engine offers a digest word |
| core_word | input | 32 | Digest word offered |
| core_done | input | 1 | Engine finished a digest |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same clock edge. A software clear of the result-set flag can coincide with core_done, and a queue pop can coincide with a digest push. The bench forces each pair by driving the bus strobe and the engine strobe on the same falling edge. It then reads status, count and the drained words to show three things: the set survived the clear, the count stayed constant, and the word order held. Random messages across all four algorithms, with surplus pushes, check the per-algorithm word limit and the drain order against a bench-side model.

// File: rtl/hrs_pkg.sv
package hrs_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_SRST    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_LEN_HI  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_LEN_LO  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_ISTAT   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_IEN     = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_ICLR    = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_RQ      = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_RQ_FILL = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_REV     = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_ID0     = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_ID1     = 8'h70;

    localparam int N_STICKY = 4;

    typedef enum logic [1:0] {
        ALG_MD5    = 2'd0,
        ALG_SHA1   = 2'd1,
        ALG_SHA224 = 2'd2,
        ALG_SHA256 = 2'd3
    } hash_alg_e;

    typedef struct packed {
        logic [1:0] order;
        hash_alg_e  alg;
    } ctrl_t;

    typedef struct packed {
        logic early_wr;
        logic empty_rd;
        logic new_set;
        logic avail;
    } evt_t;

    function automatic logic [3:0] digest_words(input hash_alg_e a);
        case (a)
            ALG_MD5:    return 4'd4;
            ALG_SHA1:   return 4'd5;
            ALG_SHA224: return 4'd7;
            default:    return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/hrs_result_queue.sv
module hrs_result_queue #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic          push_ok,
    output logic [W-1:0]  head,
    output logic [CW-1:0] fill
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          pop_ok;

    assign push_ok = push && !flush && (fill != FULL);
    assign pop_ok  = pop && !flush && (fill != '0);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/hrs_irq_ctrl.sv
module hrs_irq_ctrl
    import hrs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  evt_t                set_evt,
    input  logic                clr_we,
    input  logic [N_STICKY-1:0] clr_mask,
    input  logic                en_we,
    input  logic [N_STICKY:0]   en_wdata,
    input  logic                raw_lvl,
    output logic [N_STICKY-1:0] sticky,
    output logic [N_STICKY:0]   en_vec,
    output logic                irq
);
    logic [N_STICKY-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst || flush) sticky <= '0;
        else              sticky <= (sticky & ~clr_eff) | set_evt;
    end

    always_ff @(posedge clk) begin
        if (rst)        en_vec <= '0;
        else if (en_we) en_vec <= en_wdata;
    end

    assign irq = (|(sticky & en_vec[N_STICKY-1:0])) || (raw_lvl && en_vec[N_STICKY]);
endmodule

// File: rtl/hash_reg_shell.sv
module hash_reg_shell
    import hrs_pkg::*;
#(
    parameter int          DEPTH    = 8,
    parameter logic [31:0] REVISION = 32'h0001_0300,
    parameter logic [31:0] ID_WORD0 = 32'h4853_4831,
    parameter logic [31:0] ID_WORD1 = 32'h0000_0F04
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        msg_beat,
    output logic        core_hold,
    output logic        core_start,
    output logic [1:0]  core_algo,
    output logic [1:0]  core_order,
    output logic [63:0] core_len_bits,
    input  logic        core_push,
    input  logic [31:0] core_word,
    input  logic        core_done,
    output logic        irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic                hold_q, hold_nxt, flush;
    logic [31:0]         len_hi_q, len_lo_q;
    ctrl_t               ctrl_q;
    logic                configured_q, start_q;
    logic [3:0]          got_cnt_q;
    logic [31:0]         rdata_q, rd_mux;

    logic                wr_srst, wr_ctrl, wr_len_hi, wr_len_lo, wr_clr, wr_en;
    logic                rq_pop, rq_push_req, rq_push_ok;
    logic [31:0]         rq_head;
    logic [CW-1:0]       rq_fill;
    logic                rq_nonempty;
    evt_t                evt;
    logic [N_STICKY-1:0] sticky;
    logic [N_STICKY:0]   en_vec;

    assign wr_srst   = bus_wr && (bus_addr == OFS_SRST);
    assign wr_ctrl   = bus_wr && (bus_addr == OFS_CTRL)   && !flush;
    assign wr_len_hi = bus_wr && (bus_addr == OFS_LEN_HI) && !flush;
    assign wr_len_lo = bus_wr && (bus_addr == OFS_LEN_LO) && !flush;
    assign wr_clr    = bus_wr && (bus_addr == OFS_ICLR);
    assign wr_en     = bus_wr && (bus_addr == OFS_IEN);

    // Hold acts on the same edge that writes it
    assign hold_nxt = wr_srst ? bus_wdata[0] : hold_q;
    assign flush    = hold_nxt;

    always_ff @(posedge clk) begin
        if (rst) hold_q <= 1'b0;
        else     hold_q <= hold_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            len_hi_q     <= '0;
            len_lo_q     <= '0;
            ctrl_q       <= '0;
            configured_q <= 1'b0;
            start_q      <= 1'b0;
            got_cnt_q    <= '0;
        end else begin
            if (wr_len_hi) len_hi_q <= bus_wdata;
            if (wr_len_lo) len_lo_q <= bus_wdata;
            start_q <= wr_ctrl;
            if (wr_ctrl) begin
                ctrl_q       <= '{order: bus_wdata[9:8], alg: hash_alg_e'(bus_wdata[1:0])};
                configured_q <= 1'b1;
                got_cnt_q    <= '0;
            end else if (rq_push_ok) begin
                got_cnt_q <= got_cnt_q + 1'b1;
            end
        end
    end

    assign rq_push_req = core_push && !wr_ctrl && (got_cnt_q < digest_words(ctrl_q.alg));
    assign rq_pop      = bus_rd && (bus_addr == OFS_RQ) && !flush;
    assign rq_nonempty = (rq_fill != '0);

    hrs_result_queue #(.W(32), .DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (rq_push_req),
        .push_data (core_word),
        .pop       (rq_pop),
        .push_ok   (rq_push_ok),
        .head      (rq_head),
        .fill      (rq_fill)
    );

    always_comb begin
        evt          = '0;
        evt.avail    = rq_push_ok;
        evt.new_set  = core_done && !flush;
        evt.empty_rd = rq_pop && !rq_nonempty;
        evt.early_wr = msg_beat && !configured_q && !flush;
    end

    hrs_irq_ctrl u_irq (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .set_evt  (evt),
        .clr_we   (wr_clr),
        .clr_mask (bus_wdata[N_STICKY-1:0]),
        .en_we    (wr_en),
        .en_wdata ({bus_wdata[8], bus_wdata[N_STICKY-1:0]}),
        .raw_lvl  (rq_nonempty),
        .sticky   (sticky),
        .en_vec   (en_vec),
        .irq      (irq)
    );

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            OFS_SRST:    rd_mux = {31'b0, hold_q};
            OFS_LEN_HI:  rd_mux = len_hi_q;
            OFS_LEN_LO:  rd_mux = len_lo_q;
            OFS_CTRL:    rd_mux = {22'b0, ctrl_q.order, 6'b0, ctrl_q.alg};
            OFS_ISTAT:   rd_mux = {23'b0, rq_nonempty, 4'b0, sticky};
            OFS_IEN:     rd_mux = {23'b0, en_vec[N_STICKY], 4'b0, en_vec[N_STICKY-1:0]};
            OFS_RQ:      rd_mux = rq_nonempty ? rq_head : '0;
            OFS_RQ_FILL: rd_mux = 32'(rq_fill);
            OFS_REV:     rd_mux = REVISION;
            OFS_ID0:     rd_mux = ID_WORD0;
            OFS_ID1:     rd_mux = ID_WORD1;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata     = rdata_q;
    assign core_hold     = hold_q;
    assign core_start    = start_q;
    assign core_algo     = ctrl_q.alg;
    assign core_order    = ctrl_q.order;
    assign core_len_bits = {len_hi_q, len_lo_q};
endmodule

// File: rtl/hrs_checker.sv
module hrs_checker
    import hrs_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [7:0]          bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic                core_hold,
    input logic                core_start,
    input logic                irq,
    input logic                push_ok,
    input logic [CW-1:0]       fill,
    input logic [N_STICKY-1:0] sticky,
    input logic [N_STICKY:0]   en_vec
);
    AST_HOLD_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_SRST && bus_wdata[0]) |=> (core_hold && fill == '0 && sticky == '0)); // R2

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CTRL && !core_hold) |=> core_start); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH)); // R5

    AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == OFS_RQ && fill != '0 && !core_hold && !push_ok)
        |=> fill == $past(fill) - 1'b1); // R6

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == OFS_RQ && fill == '0 && !core_hold)
        |=> (sticky[2] && bus_rdata == '0 && fill == '0)); // R7

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
        (sticky[1] && !bus_wr && !core_hold) |=> sticky[1]); // R9

    AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (sticky[1] && en_vec[1]) |-> irq); // R10
endmodule

bind hash_reg_shell hrs_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .core_hold (core_hold),
    .core_start(core_start),
    .irq       (irq),
    .push_ok   (rq_push_ok),
    .fill      (rq_fill),
    .sticky    (sticky),
    .en_vec    (en_vec)
);

// File: tb/tb_hash_reg_shell.sv
module tb_hash_reg_shell;
    localparam logic [31:0] REV = 32'h0001_0300;
    localparam logic [31:0] ID0 = 32'h4853_4831;
    localparam logic [31:0] ID1 = 32'h0000_0F04;

    logic        clk = 0, rst = 1;
    logic        bus_wr = 0, bus_rd = 0, msg_beat = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        core_hold, core_start, core_push = 0, core_done = 0, irq;
    logic [1:0]  core_algo, core_order;
    logic [63:0] core_len_bits;
    logic [31:0] core_word = 0;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    hash_reg_shell dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msg_beat(msg_beat),
        .core_hold(core_hold), .core_start(core_start), .core_algo(core_algo),
        .core_order(core_order), .core_len_bits(core_len_bits), .core_push(core_push),
        .core_word(core_word), .core_done(core_done), .irq(irq)
    );

    function automatic int n_words(input logic [1:0] a);
        case (a)
            2'd0: return 4;
            2'd1: return 5;
            2'd2: return 7;
            default: return 8;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk); core_push = 1; core_word = w;
        @(negedge clk); core_push = 0;
    endtask

    task automatic done_pulse();
        @(negedge clk); core_done = 1;
        @(negedge clk); core_done = 0;
    endtask

    task automatic beat();
        @(negedge clk); msg_beat = 1;
        @(negedge clk); msg_beat = 0;
    endtask

    task automatic srst_pulse();
        wr(8'h00, 1);
        wr(8'h00, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, hi, lo, a, b, c;
        logic [31:0] exp_q [8];
        int dummy;
        dummy = $urandom(32'h5EED_0042);

        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state and constants
        chk("R1 irq", {31'b0, irq}, 0);
        rd(8'h10, d); chk("R1 status", d, 0);
        rd(8'h0C, d); chk("R1 control", d, 0);
        rd(8'h04, d); chk("R1 len hi", d, 0);
        rd(8'h08, d); chk("R1 len lo", d, 0);
        rd(8'h00, d); chk("R1 reset reg", d, 0);
        rd(8'h50, d); chk("R1 revision", d, REV);
        rd(8'h60, d); chk("R1 id0", d, ID0);
        rd(8'h70, d); chk("R1 id1", d, ID1);
        wr(8'h50, 32'hFFFF_FFFF); wr(8'h60, 0); wr(8'h70, 32'h1234);
        rd(8'h50, d); chk("R1 revision after write", d, REV);
        rd(8'h60, d); chk("R1 id0 after write", d, ID0);
        rd(8'h70, d); chk("R1 id1 after write", d, ID1);

        // R8 early data write before configuration
        beat();
        rd(8'h10, d); chk("R8 early write flag", d, 32'h008);
        wr(8'h0C, 32'h0000_0101);
        wr(8'h18, 32'hF);
        beat();
        rd(8'h10, d); chk("R8 no flag after configuration", d, 0);

        wr(8'h14, 32'h2);

        // Random messages: R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int m = 0; m < 16; m++) begin
            logic [1:0] alg, ord;
            int extra;
            alg = 2'(m % 4 == 0 ? $urandom_range(0, 3) : m % 4);
            ord = 2'($urandom_range(0, 3));
            hi = $urandom; lo = $urandom;
            extra = $urandom_range(0, 3);
            srst_pulse();
            rd(8'h14, d); chk("R2 enable kept over hold", d, 32'h2);
            wr(8'h04, hi); wr(8'h08, lo);
            rd(8'h04, d); chk("R3 len hi readback", d, hi);
            rd(8'h08, d); chk("R3 len lo readback", d, lo);
            chk("R3 core length upper", core_len_bits[63:32], hi);
            chk("R3 core length lower", core_len_bits[31:0], lo);
            wr(8'h0C, {22'b0, ord, 6'b0, alg});
            chk("R4 start pulse", {31'b0, core_start}, 1);
            chk("R4 algo out", {30'b0, core_algo}, {30'b0, alg});
            chk("R4 order out", {30'b0, core_order}, {30'b0, ord});
            @(negedge clk);
            chk("R4 start is single cycle", {31'b0, core_start}, 0);
            for (int i = 0; i < n_words(alg) + extra; i++) begin
                d = $urandom;
                if (i < n_words(alg)) exp_q[i] = d;
                push(d);
            end
            done_pulse();
            rd(8'h40, d); chk("R5 word count for algorithm", d, 32'(n_words(alg)));
            rd(8'h10, d); chk("R8 status after digest", d, 32'h103);
            chk("R10 irq on enabled result set", {31'b0, irq}, 1);
            for (int i = 0; i < n_words(alg); i++) begin
                rd(8'h1C, d); chk("R6 drained word in order", d, exp_q[i]);
            end
            rd(8'h10, d); chk("R8 raw bit drops when empty", d, 32'h003);
            rd(8'h1C, d); chk("R7 empty read returns zero", d, 0);
            rd(8'h10, d); chk("R7 empty read flag", d, 32'h007);
            rd(8'h40, d); chk("R7 count unchanged", d, 0);
            wr(8'h18, 32'hF);
            rd(8'h10, d); chk("R9 clear all sticky", d, 0);
            rd(8'h18, d); chk("R9 clear reads zero", d, 0);
            chk("R10 irq low after clear", {31'b0, irq}, 0);
        end

        // R2 hold flushes state and blocks writes
        srst_pulse();
        wr(8'h04, 32'hAAAA_5555); wr(8'h0C, 32'h3);
        push(32'h1111); push(32'h2222); push(32'h3333);
        wr(8'h00, 1);
        chk("R2 hold output", {31'b0, core_hold}, 1);
        rd(8'h40, d); chk("R2 queue flushed", d, 0);
        rd(8'h10, d); chk("R2 status cleared", d, 0);
        rd(8'h0C, d); chk("R2 control cleared", d, 0);
        rd(8'h04, d); chk("R2 length cleared", d, 0);
        wr(8'h08, 32'h77);
        rd(8'h08, d); chk("R2 length write ignored during hold", d, 0);
        push(32'h4444);
        rd(8'h40, d); chk("R2 push ignored during hold", d, 0);
        wr(8'h00, 0);
        chk("R2 hold released", {31'b0, core_hold}, 0);

        // R9 set and clear in the same cycle: set wins
        wr(8'h0C, 32'h0);
        @(negedge clk); bus_wr = 1; bus_addr = 8'h18; bus_wdata = 32'h2; core_done = 1;
        @(negedge clk); bus_wr = 0; core_done = 0;
        rd(8'h10, d); chk("R9 set wins over clear", d, 32'h002);
        wr(8'h18, 32'h2);
        rd(8'h10, d); chk("R9 clear alone", d, 0);

        // R6 push and pop in the same cycle
        a = $urandom; b = $urandom; c = $urandom;
        push(a); push(b);
        @(negedge clk); bus_rd = 1; bus_addr = 8'h1C; core_push = 1; core_word = c;
        @(negedge clk); bus_rd = 0; core_push = 0;
        chk("R6 head on simultaneous pop", bus_rdata, a);
        rd(8'h40, d); chk("R6 count after push and pop", d, 2);
        rd(8'h1C, d); chk("R6 second word", d, b);
        rd(8'h1C, d); chk("R6 third word", d, c);

        // R5 depth limit across two messages without draining
        srst_pulse();
        wr(8'h0C, 32'h3);
        for (int i = 0; i < 8; i++) begin
            exp_q[i] = $urandom;
            push(exp_q[i]);
        end
        wr(8'h0C, 32'h3);
        push(32'hDEAD_0001); push(32'hDEAD_0002);
        rd(8'h40, d); chk("R5 count capped at depth", d, 8);
        for (int i = 0; i < 8; i++) begin
            rd(8'h1C, d); chk("R5 words after overflow attempt", d, exp_q[i]);
        end

        // R10 raw bit interrupt enable
        wr(8'h14, 32'h100);
        chk("R10 irq low with empty queue", {31'b0, irq}, 0);
        push(32'h55);
        chk("R10 irq on raw non-empty", {31'b0, irq}, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule